// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Register Bank

This block is a small general-purpose I/O peripheral on a word-addressed 32-bit register bus. It holds two state words, one with the level driven on each pin and one with each pin's direction. It drives both words to the pads as per-pin output values and output enables. The pad levels pass through a two-stage synchroniser and can be read back through a pin-level view register.

Each state word can be written whole, and it also has two write-only alias addresses. One alias sets the bits that are written as 1 and the other clears them. Software can therefore change single pins without a read-modify-write sequence. Another agent that changes other pins between a read and a write cannot have those changes undone.

Reads are combinational from the address. Writes take effect at the next rising clock edge. The bus carries at most one access per cycle.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the output word and the direction word are both zero. All `pad_oe` and `pad_out` bits are 0, and reads of offsets 0x00 and 0x0C return 0.
- R2: A write to offset 0x00 replaces the output word with `bus_wdata[15:0]`. From the following cycle, `pad_out` and reads of 0x00 show the new value.
- R3: A write to offset 0x0C replaces the direction word with `bus_wdata[15:0]`. A 1 in bit i drives `pad_oe[i]` high, which makes pin i an output.
- R4: A write to the set alias (0x04 for the output word, 0x10 for the direction word) ORs `bus_wdata[15:0]` into that word. Bits written as 0 keep their value.
- R5: A write to the clear alias (0x08 for the output word, 0x14 for the direction word) clears every bit written as 1. Bits written as 0 keep their value.
- R6: Reads of the four alias offsets, and of any offset above 0x18, return 0. Writes to 0x18 and to unmapped offsets leave both words unchanged.
- R7: For a pin whose direction bit is 0, a read of 0x18 returns the pad level sampled through two flops. A pad change is not visible after the first rising edge, and it is visible after the second.
- R8: For a pin whose direction bit is 1, a read of 0x18 returns that pin's output-word bit, whatever the pad level.
- R9: Bits 31:16 of every read are 0. Bits 31:16 of written data have no effect on either word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Raw pad levels, asynchronous to `clk` |
| pad_out | output | 16 | Per-pin driven value |
| pad_oe | output | 16 | Per-pin output enable |

## Verification
The checks assume one access per cycle, with `bus_addr`, `bus_we` and `bus_wdata` held stable across the rising edge that performs a write. The stimulus changes bus inputs and pad levels only at falling edges, and it drops the write strobe one half period after the capturing edge. The pin-level view is checked one cycle and then two cycles after a pad change, so that the synchroniser latency is confirmed in both directions. Every read is sampled between a falling edge and the next rising edge, while the read mux is settled.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register selector; the encoding equals the word index of each register.
    typedef enum logic [2:0] {
        SEL_OUT     = 3'd0,
        SEL_OUT_SET = 3'd1,
        SEL_OUT_CLR = 3'd2,
        SEL_DIR     = 3'd3,
        SEL_DIR_SET = 3'd4,
        SEL_DIR_CLR = 3'd5,
        SEL_PIN     = 3'd6,
        SEL_NONE    = 3'd7
    } reg_sel_e;

    // One write command for a state word.
    typedef struct packed {
        logic load;   // replace the whole word
        logic set;    // OR in the written ones
        logic clr;    // clear the written ones
    } word_op_t;

    localparam int unsigned LAST_WORD = 6;

endpackage

// File: rtl/gpio_word.sv
module gpio_word
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  word_op_t     op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] bits;
    } word_state_t;

    word_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op.load) begin
            st_d.bits = wdata;
        end else if (op.set) begin
            st_d.bits = st_q.bits | wdata;
        end else if (op.clr) begin
            st_d.bits = st_q.bits & ~wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.bits;

    AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (op.set && !op.load) |=> (q == ($past(q) | $past(wdata)))); // R4

    AST_CLR_DROPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (op.clr && !op.load && !op.set) |=> (q == ($past(q) & ~$past(wdata)))); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!op.load && !op.set && !op.clr) |=> $stable(q)); // R6

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS   = 16,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned PAD_W  = BUS_W - PINS;

    typedef struct packed {
        reg_sel_e sel;
        word_op_t out_op;
        word_op_t dir_op;
    } decode_t;

    decode_t           dec;
    logic [WORD_W-1:0] word_idx;
    logic [PINS-1:0]   out_q, dir_q, pins_sync, pin_view;
    logic [PINS-1:0]   rd_bits;

    assign word_idx = bus_addr[ADDR_W-1:2];

    // Address decode and write steering.
    always_comb begin
        dec.sel = SEL_NONE;
        if (word_idx <= WORD_W'(LAST_WORD)) begin
            dec.sel = reg_sel_e'(word_idx[2:0]);
        end
        dec.out_op      = '0;
        dec.dir_op      = '0;
        dec.out_op.load = bus_we && (dec.sel == SEL_OUT);
        dec.out_op.set  = bus_we && (dec.sel == SEL_OUT_SET);
        dec.out_op.clr  = bus_we && (dec.sel == SEL_OUT_CLR);
        dec.dir_op.load = bus_we && (dec.sel == SEL_DIR);
        dec.dir_op.set  = bus_we && (dec.sel == SEL_DIR_SET);
        dec.dir_op.clr  = bus_we && (dec.sel == SEL_DIR_CLR);
    end

    gpio_word #(.W(PINS)) u_out_word (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (dec.out_op),
        .wdata (bus_wdata[PINS-1:0]),
        .q     (out_q)
    );

    gpio_word #(.W(PINS)) u_dir_word (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (dec.dir_op),
        .wdata (bus_wdata[PINS-1:0]),
        .q     (dir_q)
    );

    gpio_sync #(.W(PINS), .STAGES(2)) u_pad_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    // Per-pin view: an output pin reports its driven value.
    for (genvar i = 0; i < PINS; i++) begin : g_view
        assign pin_view[i] = dir_q[i] ? out_q[i] : pins_sync[i];
    end

    always_comb begin
        unique case (dec.sel)
            SEL_OUT: rd_bits = out_q;
            SEL_DIR: rd_bits = dir_q;
            SEL_PIN: rd_bits = pin_view;
            default: rd_bits = '0;
        endcase
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_bits};
    assign pad_out   = out_q;
    assign pad_oe    = dir_q;

    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr[ADDR_W-1:2] == WORD_W'(0)))
        |=> (pad_out == $past(bus_wdata[PINS-1:0]))); // R2

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr[ADDR_W-1:2] == WORD_W'(3)))
        |=> (pad_oe == $past(bus_wdata[PINS-1:0]))); // R3

    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr[ADDR_W-1:2] == WORD_W'(1)) || (bus_addr[ADDR_W-1:2] == WORD_W'(2)) ||
         (bus_addr[ADDR_W-1:2] == WORD_W'(4)) || (bus_addr[ADDR_W-1:2] == WORD_W'(5)))
        |-> (bus_rdata == '0)); // R6

    AST_OUTPUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:2] == WORD_W'(6))
        |-> ((bus_rdata[PINS-1:0] & pad_oe) == (pad_out & pad_oe))); // R8

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe;

    always #2 clk = ~clk;   // 250 MHz

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Scoreboard: kind 0 = bus_rdata, 1 = pad_out, 2 = pad_oe
    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        sample_ev;

    logic [15:0] out_m = '0, dir_m = '0, pad_m = '0;

    task automatic expect_item(input int kind, input logic [31:0] exp, input string tag);
        @(negedge clk);
        kind_q.push_back(kind);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        -> sample_ev;
        #1;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        kind_q.push_back(0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        -> sample_ev;
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        case (a)
            8'h00: out_m = d[15:0];
            8'h04: out_m = out_m | d[15:0];
            8'h08: out_m = out_m & ~d[15:0];
            8'h0C: dir_m = d[15:0];
            8'h10: dir_m = dir_m | d[15:0];
            8'h14: dir_m = dir_m & ~d[15:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] view_m();
        return {16'h0, (dir_m & out_m) | (~dir_m & pad_m)};
    endfunction

    // Monitor: pops each expected item and compares it with the port.
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (kind_q.size() > 0) begin
                int          k;
                logic [31:0] e, act;
                string       t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = (k == 0) ? bus_rdata : (k == 1) ? {16'h0, pad_out} : {16'h0, pad_oe};
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_item(1, 32'h0, "R1 pad_out after reset");
        expect_item(2, 32'h0, "R1 pad_oe after reset");
        bus_read(8'h00, 32'h0, "R1 output word after reset");
        bus_read(8'h0C, 32'h0, "R1 direction word after reset");

        // R2 / R9 direct output write with junk in upper bits
        bus_write(8'h00, 32'hFFFF_A5C3);
        bus_read(8'h00, {16'h0, out_m}, "R2 output word readback");
        expect_item(1, {16'h0, out_m}, "R2 pad_out follows write");
        bus_read(8'h00, 32'h0000_A5C3, "R9 upper bits read zero");

        // R4 / R5 on the output word
        bus_write(8'h04, 32'h0000_0F00);
        bus_read(8'h00, 32'h0000_AFC3, "R4 output set alias");
        bus_write(8'h08, 32'hFFFF_0003);
        bus_read(8'h00, 32'h0000_AFC0, "R5 output clear alias");
        expect_item(1, {16'h0, out_m}, "R5 pad_out after clear");

        // R6 alias and unmapped reads
        bus_read(8'h04, 32'h0, "R6 out set alias reads zero");
        bus_read(8'h08, 32'h0, "R6 out clear alias reads zero");
        bus_read(8'h10, 32'h0, "R6 dir set alias reads zero");
        bus_read(8'h14, 32'h0, "R6 dir clear alias reads zero");
        bus_read(8'h1C, 32'h0, "R6 unmapped reads zero");
        bus_read(8'hFC, 32'h0, "R6 top offset reads zero");

        // R3 direction word, R4 / R5 on it
        bus_write(8'h0C, 32'h0000_00FF);
        expect_item(2, 32'h0000_00FF, "R3 pad_oe after direction write");
        bus_write(8'h10, 32'h0000_F000);
        bus_read(8'h0C, 32'h0000_F0FF, "R4 direction set alias");
        bus_write(8'h14, 32'h0000_000F);
        bus_read(8'h0C, 32'h0000_F0F0, "R5 direction clear alias");
        expect_item(2, {16'h0, dir_m}, "R3 pad_oe after alias writes");

        // R6 writes to read-only / unmapped offsets change nothing
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h40, 32'h0000_0000);
        bus_read(8'h00, 32'h0000_AFC0, "R6 output word untouched");
        bus_read(8'h0C, 32'h0000_F0F0, "R6 direction word untouched");

        // R7 synchroniser latency on input pins
        @(negedge clk);
        pad_in = 16'h1234;
        bus_read(8'h18, view_m(), "R7 pad change hidden after one edge");
        pad_m = 16'h1234;
        bus_read(8'h18, view_m(), "R7 pad change visible after two edges");
        @(negedge clk);
        pad_in = 16'hEDCB;
        @(negedge clk);
        pad_m = 16'hEDCB;
        bus_read(8'h18, view_m(), "R7 second pattern visible");

        // R8 output pins read their driven value regardless of pad level
        bus_write(8'h00, 32'h0000_0F0F);
        bus_read(8'h18, view_m(), "R8 output pins show latch");
        bus_write(8'h0C, 32'h0000_FFFF);
        @(negedge clk);
        pad_in = 16'h0000;
        pad_m  = 16'h0000;
        repeat (2) @(negedge clk);
        bus_read(8'h18, 32'h0000_0F0F, "R8 all outputs ignore pads");
        bus_write(8'h0C, 32'h0);
        bus_read(8'h18, 32'h0000_0000, "R7 inputs again after direction clear");

        @(negedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule